// File: doc/BRIEF.md
# Gated Retriggerable One-Shot Pulse Generator

This block is a clocked monostable. It watches three asynchronous control inputs: an active-low trigger, an active-high trigger and an active-low clear. When one of these inputs makes a qualified transition, the block drives a single active-high pulse on `pulse_o`. Its complement appears on `pulse_n_o`. The pulse length is a cycle count taken from `len_i`, which takes the place of an analog resistor-capacitor network. The count is captured when the trigger is accepted.

Each input passes through its own synchronizer, and edges are found by comparing successive synchronized samples. Each kind of edge counts only when the other two inputs sit at the right levels.

A qualified edge that arrives while a pulse is running restarts the full count, so a steady stream of triggers holds the output high without limit. Pulling the clear low ends any pulse at once. Releasing the clear can itself start a pulse when both triggers are in their armed state.

Top module: `oneshot_top`

## Requirements
- R1: After reset, `pulse_o` is 0 and `pulse_n_o` is 1. No pulse appears after reset, whatever levels the inputs held during reset, unless an input changes after reset.
- R2: A 0-to-1 change on `trig_p_i` starts a pulse when `trig_n_i` is 0 and `clr_n_i` is 1.
- R3: A 1-to-0 change on `trig_n_i` starts a pulse when `trig_p_i` is 1 and `clr_n_i` is 1.
- R4: A 0-to-1 change on `clr_n_i` starts a pulse when `trig_n_i` is 0 and `trig_p_i` is 1.
- R5: While `trig_n_i` is 1 or `trig_p_i` is 0, changes on the other inputs start no pulse, and the outputs stay at `pulse_o`=0.
- R6: Timing of a pulse, with the default two-flop synchronizers:
  - An input change made between clock edges makes `pulse_o` rise after the third rising clock edge.
  - `pulse_o` then stays high for exactly `len_i` cycles.
  - `len_i` is captured when the trigger is accepted, so changing it during the pulse has no effect.
- R7: A qualified trigger during a pulse reloads the full count, so the pulse ends `len_i` cycles after the last accepted trigger.
- R8: `pulse_n_o` is always the exact complement of `pulse_o`.
- R9: While `clr_n_i` is 0, `pulse_o` is 0 in the same cycle, without waiting for a clock edge. The running count is also discarded, so the pulse does not come back when `clr_n_i` returns high with no qualifying condition.
- R10: A captured `len_i` of 0 produces no pulse.
- R11: A trigger edge that coincides with `clr_n_i` going low is ignored, because the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_n_i | input | 1 | Active-low trigger; fires on a falling edge |
| trig_p_i | input | 1 | Active-high trigger; fires on a rising edge |
| clr_n_i | input | 1 | Active-low clear; starts a pulse on release when armed |
| len_i | input | WIDTH | Pulse length in clock cycles |
| pulse_o | output | 1 | Active-high pulse |
| pulse_n_o | output | 1 | Complement of `pulse_o` |

## Verification
The bench checks the following corner cases, and what a wrong design would do in each:

- **Reset with armed inputs.** The bench holds the inputs at an armed combination through reset. A design that does not mask the synchronizer warm-up would emit a spurious pulse.
- **Retriggering mid-pulse.** The bench retriggers part-way through a pulse and measures the total width. A design that ignores retriggers, or adds the two counts, would show the wrong length.
- **Clear during a pulse.** The bench pulls the clear low mid-pulse and later releases it with the triggers disarmed. A design that only gates the output would let the old pulse reappear on release.
- **Clear and trigger together.** The bench makes a trigger edge and a clear fall in the same cycle. A design that favours the trigger would start a pulse.
- **Length handling.** The bench covers a zero length, a one-cycle length and the maximum length, and changes `len_i` mid-pulse. These expose off-by-one counting and a length that is read live instead of captured.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

    // Synchronized view of the three control inputs.
    typedef struct packed {
        logic trig_n;
        logic trig_p;
        logic clr_n;
    } lvl_t;

    // Inactive levels: both triggers disarmed, clear released.
    localparam lvl_t LVL_IDLE = '{trig_n: 1'b1, trig_p: 1'b0, clr_n: 1'b1};

endpackage

// File: rtl/oneshot_sync.sv
module oneshot_sync
    import oneshot_pkg::*;
#(
    parameter int   STAGES  = 2,
    parameter lvl_t RST_VAL = LVL_IDLE
) (
    input  logic clk,
    input  logic rst_n,
    input  lvl_t d,
    output lvl_t q
);

    typedef struct packed {
        lvl_t [STAGES-1:0] stg;
    } sync_st_t;

    sync_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stg[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.stg <= {STAGES{RST_VAL}};
        end else begin
            s_q <= s_d;
        end
    end

    assign q = s_q.stg[STAGES-1];

endmodule

// File: rtl/oneshot_qual.sv
module oneshot_qual
    import oneshot_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  lvl_t lvl,
    output logic fire,
    output logic clr_act
);

    // Edges are trusted only once both the synchronizer and the
    // previous-sample register hold real input history.
    localparam int READY = STAGES + 1;
    localparam int SW    = $clog2(READY + 1);

    typedef struct packed {
        lvl_t          prev;
        logic [SW-1:0] settle;
    } qual_st_t;

    qual_st_t s_d, s_q;
    logic     ready;
    logic     rise_p, fall_n, rise_c;

    always_comb begin
        ready  = (s_q.settle == SW'(READY));
        rise_p = lvl.trig_p & ~s_q.prev.trig_p;
        fall_n = ~lvl.trig_n & s_q.prev.trig_n;
        rise_c = lvl.clr_n & ~s_q.prev.clr_n;

        fire = ready & lvl.clr_n &
               ((rise_p & ~lvl.trig_n) |
                (fall_n &  lvl.trig_p) |
                (rise_c & ~lvl.trig_n & lvl.trig_p));
        clr_act = ~lvl.clr_n;

        s_d        = s_q;
        s_d.prev   = lvl;
        s_d.settle = ready ? s_q.settle : s_q.settle + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prev   <= LVL_IDLE;
            s_q.settle <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             clr_act,
    input  logic [WIDTH-1:0] len,
    output logic [WIDTH-1:0] cnt,
    output logic             busy
);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } tmr_st_t;

    tmr_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_act) begin
            s_d.cnt = '0;
        end else if (fire) begin
            s_d.cnt = len;
        end else if (s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt  = s_q.cnt;
    assign busy = (s_q.cnt != '0);

endmodule

// File: rtl/oneshot_top.sv
module oneshot_top
    import oneshot_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_n_i,
    input  logic             trig_p_i,
    input  logic             clr_n_i,
    input  logic [WIDTH-1:0] len_i,
    output logic             pulse_o,
    output logic             pulse_n_o
);

    lvl_t             lvl_raw;
    lvl_t             lvl_sync;
    logic             fire;
    logic             clr_act;
    logic [WIDTH-1:0] cnt;
    logic             busy;

    assign lvl_raw = '{trig_n: trig_n_i, trig_p: trig_p_i, clr_n: clr_n_i};

    oneshot_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (LVL_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lvl_raw),
        .q     (lvl_sync)
    );

    oneshot_qual #(
        .STAGES (SYNC_STAGES)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl_sync),
        .fire    (fire),
        .clr_act (clr_act)
    );

    oneshot_timer #(
        .WIDTH (WIDTH)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .clr_act (clr_act),
        .len     (len_i),
        .cnt     (cnt),
        .busy    (busy)
    );

    // The raw clear level masks the output so that a clear takes effect
    // without waiting for the synchronizer.
    assign pulse_o   = busy & clr_n_i;
    assign pulse_n_o = ~pulse_o;

endmodule

// File: rtl/oneshot_chk.sv
module oneshot_chk
    import oneshot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input lvl_t             lvl,
    input logic             fire,
    input logic             clr_act,
    input logic [WIDTH-1:0] cnt,
    input logic [WIDTH-1:0] len_i,
    input logic             pulse_o
);

    always_comb begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (!pulse_o);
        end
    end

    p_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl.trig_n || !lvl.trig_p) && !(lvl.clr_n && !lvl.trig_n && !lvl.trig_p && 1'b0) |->
        !fire || (!lvl.trig_n && lvl.clr_n) || (lvl.trig_p && lvl.clr_n && !lvl.trig_n));

    p_armed_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl.trig_n && !lvl.trig_p) |-> !fire);

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !clr_act) |=> (cnt == $past(len_i)));

    p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !clr_act && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (cnt == '0));

    p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && len_i == '0) |=> (cnt == '0));

    p_clear_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |-> !fire);

endmodule

bind oneshot_top oneshot_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl     (lvl_sync),
    .fire    (fire),
    .clr_act (clr_act),
    .cnt     (cnt),
    .len_i   (len_i),
    .pulse_o (pulse_o)
);

// File: tb/sim_oneshot_top.sv
module sim_oneshot_top;

    logic       clk     = 1'b0;
    logic       rst_n   = 1'b0;
    logic       trig_n  = 1'b1;
    logic       trig_p  = 1'b0;
    logic       clr_n   = 1'b1;
    logic [7:0] len     = 8'd5;
    logic       pulse;
    logic       pulse_n;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    oneshot_top #(.WIDTH(8), .SYNC_STAGES(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_n_i  (trig_n),
        .trig_p_i  (trig_p),
        .clr_n_i   (clr_n),
        .len_i     (len),
        .pulse_o   (pulse),
        .pulse_n_o (pulse_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Counts negedges after the caller's stimulus; index 1 is the first.
    task automatic observe(input int n, output int first, output int tot,
                           output int last, output int cbad);
        first = -1; tot = 0; last = -1; cbad = 0;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (pulse_n !== ~pulse) cbad++;
            if (pulse === 1'b1) begin
                if (first < 0) first = k;
                last = k;
                tot++;
            end
        end
    endtask

    task automatic go_idle();
        @(negedge clk);
        trig_n = 1'b1; trig_p = 1'b0; clr_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic test_reset();
        int f, t, l, c;
        rst_n = 1'b0; trig_n = 1'b0; trig_p = 1'b1; clr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "pulse_o in reset", pulse, 0);
        check("R8", "pulse_n_o in reset", pulse_n, 1);
        rst_n = 1'b1;
        observe(20, f, t, l, c);
        check("R1", "pulses after reset with armed inputs", t, 0);
        check("R8", "complement mismatches", c, 0);
        go_idle();
    endtask

    task automatic test_rise_p();
        int first, tot, last, cbad;
        @(negedge clk); trig_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R5", "trig_n fall with trig_p low", pulse, 0);
        len = 8'd5; trig_p = 1'b1;
        first = -1; tot = 0; last = -1; cbad = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (pulse_n !== ~pulse) cbad++;
            if (pulse) begin if (first < 0) first = k; last = k; tot++; end
            if (k == 4) len = 8'd2;
        end
        check("R2", "trig_p rise start index", first, 3);
        check("R6", "width with len changed mid-pulse", tot, 5);
        check("R6", "contiguous end", last, 7);
        check("R8", "complement mismatches", cbad, 0);
        go_idle();
    endtask

    task automatic test_fall_n(input logic [7:0] w, input int exp_tot);
        int f, t, l, c;
        len = w;
        @(negedge clk); trig_p = 1'b1;
        repeat (6) @(negedge clk);
        check("R5", "trig_p rise with trig_n high", pulse, 0);
        trig_n = 1'b0;
        observe(exp_tot + 10, f, t, l, c);
        check("R3", "trig_n fall start index", f, 3);
        check("R6", "width", t, exp_tot);
        check("R6", "contiguous end", l, exp_tot + 2);
        check("R8", "complement mismatches", c, 0);
        go_idle();
    endtask

    task automatic test_clr_release();
        int f, t, l, c;
        len = 8'd12;
        @(negedge clk); clr_n = 1'b0;
        repeat (4) @(negedge clk);
        trig_n = 1'b0; trig_p = 1'b1;
        observe(8, f, t, l, c);
        check("R9", "arming while clear low", t, 0);
        clr_n = 1'b1;
        observe(25, f, t, l, c);
        check("R4", "clear release start index", f, 3);
        check("R4", "clear release width", t, 12);
        go_idle();
    endtask

    task automatic test_blocked();
        int f, t, l, c;
        len = 8'd6;
        @(negedge clk); trig_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            trig_p = 1'b1; repeat (4) @(negedge clk);
            trig_p = 1'b0; repeat (4) @(negedge clk);
        end
        check("R5", "trig_p toggles while trig_n high", pulse, 0);
        clr_n = 1'b0; repeat (4) @(negedge clk); clr_n = 1'b1;
        observe(10, f, t, l, c);
        check("R5", "pulses while trig_n high", t, 0);
        for (int i = 0; i < 3; i++) begin
            trig_n = 1'b0; repeat (4) @(negedge clk);
            trig_n = 1'b1; repeat (4) @(negedge clk);
        end
        observe(6, f, t, l, c);
        check("R5", "trig_n toggles while trig_p low", t, 0);
        go_idle();
    endtask

    task automatic test_retrigger();
        int first, tot, last, cbad;
        len = 8'd8;
        @(negedge clk); trig_n = 1'b0;
        repeat (6) @(negedge clk);
        trig_p = 1'b1;
        first = -1; tot = 0; last = -1; cbad = 0;
        for (int k = 1; k <= 30; k++) begin
            @(negedge clk);
            if (pulse_n !== ~pulse) cbad++;
            if (pulse) begin if (first < 0) first = k; last = k; tot++; end
            if (k == 2) trig_p = 1'b0;
            if (k == 5) trig_p = 1'b1;
        end
        check("R7", "retrigger start index", first, 3);
        check("R7", "retriggered end index", last, 15);
        check("R7", "retriggered high cycles", tot, 13);
        check("R8", "complement mismatches", cbad, 0);
        go_idle();
    endtask

    task automatic test_clear_mid();
        int f, t, l, c;
        len = 8'd20;
        @(negedge clk); trig_n = 1'b0;
        repeat (6) @(negedge clk);
        trig_p = 1'b1;
        repeat (6) @(negedge clk);
        check("R9", "pulse running before clear", pulse, 1);
        clr_n = 1'b0;
        #1;
        check("R9", "pulse_o right after clear", pulse, 0);
        check("R8", "pulse_n_o right after clear", pulse_n, 1);
        repeat (3) @(negedge clk);
        trig_n = 1'b1;
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        observe(30, f, t, l, c);
        check("R9", "pulse after clear release", t, 0);
        go_idle();
    endtask

    task automatic test_zero();
        int f, t, l, c;
        len = 8'd0;
        @(negedge clk); trig_n = 1'b0;
        repeat (6) @(negedge clk);
        trig_p = 1'b1;
        observe(12, f, t, l, c);
        check("R10", "zero length pulses", t, 0);
        go_idle();
    endtask

    task automatic test_tie();
        int f, t, l, c;
        len = 8'd9;
        @(negedge clk); trig_n = 1'b0;
        repeat (6) @(negedge clk);
        trig_p = 1'b1; clr_n = 1'b0;
        observe(8, f, t, l, c);
        check("R11", "trigger with simultaneous clear", t, 0);
        trig_n = 1'b1;
        repeat (4) @(negedge clk);
        clr_n = 1'b1;
        observe(15, f, t, l, c);
        check("R11", "after clear released disarmed", t, 0);
        go_idle();
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        test_rise_p();
        test_fall_n(8'd1, 1);
        test_fall_n(8'd255, 255);
        test_clr_release();
        test_blocked();
        test_retrigger();
        test_clear_mid();
        test_zero();
        test_tie();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule